// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a set of one-bit hardware semaphores that two ports, left and right, use to agree on who owns a shared resource, such as a region of a two-port memory. A port claims a semaphore by writing 0 to it and gives it up by writing 1. Each port reads its own view of the semaphore. The owner reads 0. The other port reads 1, and so does either port when the semaphore is free.

If the port that does not own a semaphore writes 0 to it, the request is stored. The semaphore then passes to that port in the same clock cycle in which the owner releases it. If both ports claim a free semaphore in the same cycle, the left port wins and the right request is stored. Read data goes into a per-port output register, so a write from the other port in the same cycle cannot change the value being returned. The block is synchronous to one clock. A parameter selects whether it has a synchronous reset that frees every semaphore.

Top module: `dpsem_unit`

## Requirements
- R1: A port accesses a semaphore only in a cycle where its select input is low and its memory enable input is high. Any other combination neither changes the semaphores nor loads the read register.
- R2: The semaphore is chosen by address bits [2:0] (log2 of the semaphore count). All higher address bits are ignored.
- R3: On a write, only data bit 0 is used: 0 requests the semaphore and 1 releases it. All other data bits are ignored.
- R4: A port that writes 0 to a free semaphore becomes its owner. It then reads 0 and the other port reads 1. The two ports never own the same semaphore.
- R5: When the owner writes 1 and no request from the other port is stored, the semaphore becomes free and both ports read 1.
- R6: A 0 written by the non-owner while the semaphore is owned is stored. On the owner's release, ownership passes to that port in the same cycle, and from then on it reads 0.
- R7: A 1 written by the non-owner cancels its stored request. If no request is stored, such a write has no effect.
- R8: A read, with write/read high, loads the selected semaphore value into every bit of that port's read data register. The register keeps its value until the next read. The drive flag is high in the cycle after a read that had output enable low, and low otherwise.
- R9: A read returns the state before the clock edge, so a write from the other port in the same cycle cannot change the captured value.
- R10: When both ports write 0 to the same free semaphore in one cycle, the left port wins and the right request is stored.
- R11: With the reset option on (the default), a synchronous reset frees all semaphores, clears all stored requests, and clears both read registers and drive flags.
- R12: The semaphores are independent. An access to one never changes another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high (used when the reset option is on) |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_mem_en_n | input | 1 | Left memory enable, active low; must be high for a semaphore access |
| l_wr_n | input | 1 | Left write/read: 0 writes, 1 reads |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | PORT_ADDR_W | Left address; low bits pick the semaphore |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left read data register |
| l_drive | output | 1 | Left read data is being driven |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_mem_en_n | input | 1 | Right memory enable, active low; must be high for a semaphore access |
| r_wr_n | input | 1 | Right write/read: 0 writes, 1 reads |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | PORT_ADDR_W | Right address; low bits pick the semaphore |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right read data register |
| r_drive | output | 1 | Right read data is being driven |

## Verification
The internal state is visible only through reads, so a wrong owner or a lost stored request shows up on the next read of that semaphore. It appears in the read register one edge after the read is issued: one port reads 0 where 1 is expected, or the reverse. A hand-over that fires too early or too late shows up when both ports read the semaphore in the cycle right after the release. A corrupted read register shows up either as a mixed word, which is no longer all zeros or all ones, or as a value that changes while no read is issued.

// File: rtl/dpsem_pkg.sv
package dpsem_pkg;

   typedef enum logic [1:0] {
      SEM_FREE  = 2'd0,
      SEM_LEFT  = 2'd1,
      SEM_RIGHT = 2'd2
   } sem_owner_e;

   // Request state of the non-owning side after its write in this cycle.
   function automatic logic waiter_req(input logic wr, input logic wbit,
                                       input logic held);
      return wr ? ~wbit : held;
   endfunction

endpackage

// File: rtl/dpsem_decode.sv
module dpsem_decode #(
   parameter int NUM_SEM     = 8,
   parameter int PORT_ADDR_W = 14,
   parameter int DATA_W      = 8,
   localparam int SEL_W      = $clog2(NUM_SEM)
) (
   input  logic                   sel_n,
   input  logic                   mem_en_n,
   input  logic                   wr_n,
   input  logic [PORT_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]      wdata,
   output logic                   acc,
   output logic                   rd,
   output logic [SEL_W-1:0]       idx,
   output logic                   wbit,
   output logic [NUM_SEM-1:0]     wr_hot
);
   logic we;

   assign acc  = ~sel_n & mem_en_n;
   assign rd   = acc & wr_n;
   assign we   = acc & ~wr_n;
   assign idx  = addr[SEL_W-1:0];
   assign wbit = wdata[0];

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_hot
      assign wr_hot[i] = we && (idx == SEL_W'(i));
   end

   logic unused_ok;
   assign unused_ok = ^{addr[PORT_ADDR_W-1:SEL_W], wdata[DATA_W-1:1]};
endmodule

// File: rtl/dpsem_cell.sv
module dpsem_cell
   import dpsem_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic l_wr,
   input  logic l_bit,
   input  logic r_wr,
   input  logic r_bit,
   output logic own_l,
   output logic own_r,
   output logic pend
);
   sem_owner_e owner_q, owner_d;
   logic       pend_q, pend_d;
   logic       req;

   always_comb begin
      owner_d = owner_q;
      pend_d  = 1'b0;
      req     = 1'b0;
      unique case (owner_q)
         SEM_FREE: begin
            if (l_wr && !l_bit) begin
               owner_d = SEM_LEFT;
               pend_d  = r_wr && !r_bit;
            end else if (r_wr && !r_bit) begin
               owner_d = SEM_RIGHT;
            end
         end
         SEM_LEFT: begin
            req = waiter_req(r_wr, r_bit, pend_q);
            if (l_wr && l_bit) owner_d = req ? SEM_RIGHT : SEM_FREE;
            else               pend_d  = req;
         end
         SEM_RIGHT: begin
            req = waiter_req(l_wr, l_bit, pend_q);
            if (r_wr && r_bit) owner_d = req ? SEM_LEFT : SEM_FREE;
            else               pend_d  = req;
         end
         default: owner_d = SEM_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         owner_q <= SEM_FREE;
         pend_q  <= 1'b0;
      end else begin
         owner_q <= owner_d;
         pend_q  <= pend_d;
      end
   end

   assign own_l = (owner_q == SEM_LEFT);
   assign own_r = (owner_q == SEM_RIGHT);
   assign pend  = pend_q;
endmodule

// File: rtl/dpsem_readout.sv
module dpsem_readout #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 8,
   localparam int SEL_W  = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rd,
   input  logic               oe_n,
   input  logic [SEL_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] view,
   output logic [DATA_W-1:0]  rdata,
   output logic               drive
);
   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
         drive <= 1'b0;
      end else begin
         drive <= rd & ~oe_n;
         if (rd) rdata <= {DATA_W{view[idx]}};
      end
   end
endmodule

// File: rtl/dpsem_unit.sv
module dpsem_unit #(
   parameter int NUM_SEM        = 8,
   parameter int PORT_ADDR_W    = 14,
   parameter int DATA_W         = 8,
   parameter bit USE_SYNC_RESET = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   l_sel_n,
   input  logic                   l_mem_en_n,
   input  logic                   l_wr_n,
   input  logic                   l_oe_n,
   input  logic [PORT_ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0]      l_wdata,
   output logic [DATA_W-1:0]      l_rdata,
   output logic                   l_drive,
   input  logic                   r_sel_n,
   input  logic                   r_mem_en_n,
   input  logic                   r_wr_n,
   input  logic                   r_oe_n,
   input  logic [PORT_ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0]      r_wdata,
   output logic [DATA_W-1:0]      r_rdata,
   output logic                   r_drive
);
   localparam int SEL_W = $clog2(NUM_SEM);

   initial begin
      if (NUM_SEM < 2 || (1 << SEL_W) != NUM_SEM)
         $error("dpsem_unit: NUM_SEM must be a power of two, at least 2");
      if (PORT_ADDR_W <= SEL_W)
         $error("dpsem_unit: PORT_ADDR_W must exceed the select width");
      if (DATA_W < 1)
         $error("dpsem_unit: DATA_W must be at least 1");
   end

   logic rst_int;
   if (USE_SYNC_RESET) begin : g_rst
      assign rst_int = rst;
   end else begin : g_no_rst
      assign rst_int = 1'b0;
      logic unused_rst;
      assign unused_rst = rst;
   end

   logic               l_acc, l_rd, l_wbit, r_acc, r_rd, r_wbit;
   logic [SEL_W-1:0]   l_idx, r_idx;
   logic [NUM_SEM-1:0] l_hot, r_hot, own_l, own_r, pend;

   dpsem_decode #(.NUM_SEM(NUM_SEM), .PORT_ADDR_W(PORT_ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .sel_n(l_sel_n), .mem_en_n(l_mem_en_n), .wr_n(l_wr_n), .addr(l_addr),
      .wdata(l_wdata), .acc(l_acc), .rd(l_rd), .idx(l_idx), .wbit(l_wbit), .wr_hot(l_hot));

   dpsem_decode #(.NUM_SEM(NUM_SEM), .PORT_ADDR_W(PORT_ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .sel_n(r_sel_n), .mem_en_n(r_mem_en_n), .wr_n(r_wr_n), .addr(r_addr),
      .wdata(r_wdata), .acc(r_acc), .rd(r_rd), .idx(r_idx), .wbit(r_wbit), .wr_hot(r_hot));

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
      dpsem_cell u_cell (
         .clk(clk), .rst(rst_int),
         .l_wr(l_hot[i]), .l_bit(l_wbit),
         .r_wr(r_hot[i]), .r_bit(r_wbit),
         .own_l(own_l[i]), .own_r(own_r[i]), .pend(pend[i]));
   end

   dpsem_readout #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_out_l (
      .clk(clk), .rst(rst_int), .rd(l_rd), .oe_n(l_oe_n), .idx(l_idx),
      .view(~own_l), .rdata(l_rdata), .drive(l_drive));

   dpsem_readout #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_out_r (
      .clk(clk), .rst(rst_int), .rd(r_rd), .oe_n(r_oe_n), .idx(r_idx),
      .view(~own_r), .rdata(r_rdata), .drive(r_drive));
endmodule

// File: rtl/dpsem_unit_chk.sv
module dpsem_unit_chk #(
   parameter int NUM_SEM = 8,
   parameter int DATA_W  = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               l_acc,
   input logic               r_acc,
   input logic               l_rd,
   input logic               r_rd,
   input logic [DATA_W-1:0]  l_rdata,
   input logic [DATA_W-1:0]  r_rdata,
   input logic [NUM_SEM-1:0] own_l,
   input logic [NUM_SEM-1:0] own_r,
   input logic [NUM_SEM-1:0] pend
);
   // R11
   reset_free_chk: assert property (@(posedge clk)
      rst |=> (own_l == '0 && own_r == '0 && pend == '0 && l_rdata == '0 && r_rdata == '0));

   // R4
   single_owner_chk: assert property (@(posedge clk) disable iff (rst)
      (own_l & own_r) == '0);

   // R6
   pend_needs_owner_chk: assert property (@(posedge clk) disable iff (rst)
      (pend & ~(own_l | own_r)) == '0);

   // R1
   idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
      (!l_acc && !r_acc) |=> ($stable(own_l) && $stable(own_r) && $stable(pend)));

   // R8
   l_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      (l_rdata == '0 || l_rdata == '1));

   // R8
   r_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      (r_rdata == '0 || r_rdata == '1));

   // R9
   l_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !l_rd |=> $stable(l_rdata));

   // R9
   r_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !r_rd |=> $stable(r_rdata));
endmodule

bind dpsem_unit dpsem_unit_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst(rst_int), .l_acc(l_acc), .r_acc(r_acc), .l_rd(l_rd), .r_rd(r_rd),
   .l_rdata(l_rdata), .r_rdata(r_rdata), .own_l(own_l), .own_r(own_r), .pend(pend));

// File: tb/dpsem_unit_tb.sv
`timescale 1ns/1ps
module dpsem_unit_tb_top;
   localparam int PA = 14;
   localparam int DW = 8;
   localparam int OP_IDLE = 0, OP_W0 = 1, OP_W1 = 2, OP_RD = 3;
   localparam int NVEC = 13;
   // {left op, right op, expected left view, expected right view}, semaphore 2
   localparam logic [5:0] VEC [NVEC] = '{
      {2'd1, 2'd0, 1'b0, 1'b1},
      {2'd0, 2'd1, 1'b0, 1'b1},
      {2'd2, 2'd0, 1'b1, 1'b0},
      {2'd1, 2'd0, 1'b1, 1'b0},
      {2'd0, 2'd2, 1'b0, 1'b1},
      {2'd2, 2'd0, 1'b1, 1'b1},
      {2'd0, 2'd1, 1'b1, 1'b0},
      {2'd0, 2'd2, 1'b1, 1'b1},
      {2'd1, 2'd0, 1'b0, 1'b1},
      {2'd2, 2'd0, 1'b1, 1'b1},
      {2'd0, 2'd1, 1'b1, 1'b0},
      {2'd2, 2'd0, 1'b1, 1'b0},
      {2'd0, 2'd2, 1'b1, 1'b1}
   };

   logic clk = 1'b0, rst = 1'b1;
   logic l_sel_n = 1'b1, l_mem_en_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b0;
   logic r_sel_n = 1'b1, r_mem_en_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b0;
   logic [PA-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic [DW-1:0] l_rdata, r_rdata;
   logic l_drive, r_drive;
   logic [PA-4:0] l_hi = '0, r_hi = '0;
   logic [DW-1:0] wpat = 8'h00;
   logic l_en_val = 1'b1;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   dpsem_unit dut_i (
      .clk(clk), .rst(rst),
      .l_sel_n(l_sel_n), .l_mem_en_n(l_mem_en_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_drive(l_drive),
      .r_sel_n(r_sel_n), .r_mem_en_n(r_mem_en_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_drive(r_drive));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int lop, input int ls, input int rop, input int rs);
      l_sel_n = (lop == OP_IDLE); l_mem_en_n = l_en_val;
      l_wr_n = !(lop == OP_W0 || lop == OP_W1);
      l_wdata = (lop == OP_W0) ? (wpat & 8'hFE) : (wpat | 8'h01);
      l_addr = {l_hi, 3'(ls)};
      r_sel_n = (rop == OP_IDLE); r_mem_en_n = 1'b1;
      r_wr_n = !(rop == OP_W0 || rop == OP_W1);
      r_wdata = (rop == OP_W0) ? (wpat & 8'hFE) : (wpat | 8'h01);
      r_addr = {r_hi, 3'(rs)};
      @(posedge clk); @(negedge clk);
      l_sel_n = 1'b1; r_sel_n = 1'b1; l_wr_n = 1'b1; r_wr_n = 1'b1;
   endtask

   task automatic rd_both(input string req, input int s, input logic el, input logic er);
      cyc(OP_RD, s, OP_RD, s);
      chk(req, l_rdata, {DW{el}});
      chk(req, r_rdata, {DW{er}});
   endtask

   initial begin
      #(20 * 20000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R11 reset state of the read path
      chk("R11", l_rdata, 8'h00);
      chk("R11", {7'b0, l_drive}, 8'h00);
      for (int s = 0; s < 8; s++) rd_both("R11", s, 1'b1, 1'b1);
      // R8 drive flag follows a read with output enable low
      chk("R8", {7'b0, l_drive}, 8'h01);

      // Table: request, deny, release, hand-over on semaphore 2 (R4 R5 R6 R7)
      for (int v = 0; v < NVEC; v++) begin
         cyc(int'(VEC[v][5:4]), 2, int'(VEC[v][3:2]), 2);
         rd_both($sformatf("R4/R5/R6/R7 step %0d", v), 2, VEC[v][1], VEC[v][0]);
      end

      // R1: memory enable low blocks the access
      l_en_val = 1'b0; cyc(OP_W0, 1, OP_IDLE, 0); l_en_val = 1'b1;
      rd_both("R1", 1, 1'b1, 1'b1);
      // R2: upper address bits ignored; R3: upper data bits ignored
      l_hi = '1; wpat = 8'hFE; cyc(OP_W0, 5, OP_IDLE, 0); l_hi = '0;
      rd_both("R2 R3", 5, 1'b0, 1'b1);
      wpat = 8'h00; r_hi = 11'h2A5; cyc(OP_IDLE, 0, OP_W0, 5); r_hi = '0;
      // R9: right reads while left releases with right pending
      cyc(OP_W1, 5, OP_RD, 5);
      chk("R9", r_rdata, 8'hFF);
      cyc(OP_IDLE, 0, OP_IDLE, 0);
      chk("R9", r_rdata, 8'hFF);
      rd_both("R6", 5, 1'b1, 1'b0);
      // R7: pending request cancelled by a write of 1
      cyc(OP_W0, 5, OP_IDLE, 0);
      cyc(OP_W1, 5, OP_IDLE, 0);
      cyc(OP_IDLE, 0, OP_W1, 5);
      rd_both("R7", 5, 1'b1, 1'b1);
      // R10: same-cycle requests, left wins, right pending
      cyc(OP_W0, 3, OP_W0, 3);
      rd_both("R10", 3, 1'b0, 1'b1);
      cyc(OP_W1, 3, OP_IDLE, 0);
      rd_both("R10", 3, 1'b1, 1'b0);
      // R12: neighbours untouched
      rd_both("R12", 4, 1'b1, 1'b1);
      // R8: output enable high, no drive
      l_oe_n = 1'b1; cyc(OP_RD, 3, OP_IDLE, 0); l_oe_n = 1'b0;
      chk("R8", {7'b0, l_drive}, 8'h00);
      chk("R8", l_rdata, 8'hFF);
      // R11: reset mid-run frees everything
      rst = 1'b1; cyc(OP_IDLE, 0, OP_IDLE, 0); rst = 1'b0;
      chk("R11", r_rdata, 8'h00);
      rd_both("R11", 3, 1'b1, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule